// File: doc/BRIEF.md
# Configurable Partial Bypass Controller

This block decides, for every source operand in the register-read stage of an in-order pipeline, where that operand's value comes from. Three result pipelines run side by side: an execute pipe, a memory pipe and a long-latency pipe, each three stages deep. Only some stages are wired back to the operand multiplexers, and each operand carries its own 7-bit enable mask. The mask says which of those wired stages may actually forward to that operand.

Each operand's register index is compared against the destination of every valid in-flight instruction. Only the youngest writer of that register counts. When that writer sits in an enabled stage and its result is ready, the block selects that stage. When no in-flight instruction writes the register, it selects the register-file read port. In every other case it raises a hazard for the operand, and the OR of all operand hazards holds the register-read stage.

The block is purely combinational and has no state. It is meant to sit beside the operand multiplexers, which it drives with a one-hot select for each operand.

Top module: `pb_bypass_ctrl`

## Requirements
- R1: The in-flight stage inputs (`stg_valid`, `stg_dest`, `stg_ready`) are indexed by slot, youngest first: 0=X1, 1=M1, 2=D1, 3=X2, 4=M2, 5=D2, 6=XWB, 7=MWB, 8=DWB. The path mask bits are 0=X1, 1=X2, 2=XWB, 3=M2, 4=MWB, 5=D2, 6=DWB, so mask value 28 enables only XWB, M2 and MWB. M1 and D1 have no forwarding path.
- R2: Each operand select is 8 bits. Bit 0 is the register file, and bit k+1 is the stage of mask bit k. The select is one-hot, or all zero when that operand has a hazard.
- R3: An operand with register index 0, or with its used flag low, selects the register file and raises no hazard, whatever the stages hold.
- R4: When several valid stages write the operand's register, only the lowest-numbered (youngest) slot decides the outcome; older writers have no effect, even when the youngest one stalls.
- R5: A youngest matching producer whose path bit is set and whose result is ready is forwarded: its select bit is set and it raises no hazard.
- R6: A youngest matching producer whose path bit is clear, or which sits in M1 or D1, raises a hazard for that operand.
- R7: A youngest matching producer whose result is not ready raises a hazard even when its path bit is set.
- R8: With no valid matching producer, the operand selects the register file and raises no hazard.
- R9: `op_stall` is high exactly when at least one operand has a hazard, and each operand is resolved using only its own mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_reg | input | NUM_OPS*REG_W | Source register index per operand |
| op_used | input | NUM_OPS | Operand is actually read by the instruction |
| op_path_en | input | NUM_OPS*7 | Per-operand forwarding path enable mask |
| stg_valid | input | 9 | Slot holds a valid instruction with a destination |
| stg_dest | input | 9*REG_W | Destination register index per slot |
| stg_ready | input | 9 | Result of the slot has been produced |
| op_sel | output | NUM_OPS*8 | One-hot source select per operand |
| op_stall | output | 1 | Hold the register-read stage |

## Verification
The bench builds the block with `REG_W` = 3 and two operands. This small register space makes register collisions between random stage contents frequent.

With those values, a lone producer can be placed in each of the nine slots, both ready and not ready, under all 128 masks. Every ordered pair of colliding writers can also be swept under all 128 masks, and random mixes of both operands can be compared against an arithmetic model. Together these reach every youngest-writer, missing-path and not-ready combination.

// File: rtl/pb_pkg.sv
package pb_pkg;

    localparam int NUM_PATH = 7;
    localparam int NUM_SLOT = 9;
    localparam int SEL_W    = NUM_PATH + 1;

    typedef enum logic [3:0] {
        SL_X1, SL_M1, SL_D1, SL_X2, SL_M2, SL_D2, SL_XWB, SL_MWB, SL_DWB
    } slot_e;

    // Mask bit carried by a slot, -1 when the slot has no forwarding wire.
    function automatic int slot_path(int slot);
        case (slot)
            int'(SL_X1):  return 0;
            int'(SL_X2):  return 1;
            int'(SL_XWB): return 2;
            int'(SL_M2):  return 3;
            int'(SL_MWB): return 4;
            int'(SL_D2):  return 5;
            int'(SL_DWB): return 6;
            default:      return -1;
        endcase
    endfunction

    // Slot that drives a given mask bit.
    function automatic int path_slot(int path);
        case (path)
            0:       return int'(SL_X1);
            1:       return int'(SL_X2);
            2:       return int'(SL_XWB);
            3:       return int'(SL_M2);
            4:       return int'(SL_MWB);
            5:       return int'(SL_D2);
            default: return int'(SL_DWB);
        endcase
    endfunction

endpackage

// File: rtl/pb_match.sv
module pb_match
    import pb_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0]               src_reg,
    input  logic                           src_used,
    input  logic [NUM_SLOT-1:0]            stg_valid,
    input  logic [NUM_SLOT-1:0][REG_W-1:0] stg_dest,
    output logic [NUM_SLOT-1:0]            hit
);

    logic live;

    assign live = src_used && (src_reg != '0);

    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_cmp
        assign hit[s] = live && stg_valid[s] && (stg_dest[s] == src_reg);
    end

endmodule

// File: rtl/pb_pick.sv
module pb_pick
    import pb_pkg::*;
(
    input  logic [NUM_SLOT-1:0] hit,
    input  logic [NUM_SLOT-1:0] stg_ready,
    input  logic [NUM_PATH-1:0] path_en,
    output logic [SEL_W-1:0]    sel,
    output logic                hazard
);

    logic [NUM_SLOT:0]   none_younger;
    logic [NUM_SLOT-1:0] grant;
    logic [NUM_SLOT-1:0] usable;

    assign none_younger[0] = 1'b1;

    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
        localparam int P = slot_path(s);
        assign none_younger[s+1] = none_younger[s] & ~hit[s];
        assign grant[s]          = hit[s] & none_younger[s];
        if (P >= 0) begin : g_wired
            assign usable[s] = path_en[P] & stg_ready[s];
            assign sel[P+1]  = grant[s] & usable[s];
        end else begin : g_unwired
            assign usable[s] = 1'b0;
        end
    end

    assign sel[0] = none_younger[NUM_SLOT];
    assign hazard = |(grant & ~usable);

endmodule

// File: rtl/pb_bypass_ctrl.sv
module pb_bypass_ctrl
    import pb_pkg::*;
#(
    parameter int REG_W   = 5,
    parameter int NUM_OPS = 2
) (
    input  logic [NUM_OPS-1:0][REG_W-1:0]    op_reg,
    input  logic [NUM_OPS-1:0]               op_used,
    input  logic [NUM_OPS-1:0][NUM_PATH-1:0] op_path_en,
    input  logic [NUM_SLOT-1:0]              stg_valid,
    input  logic [NUM_SLOT-1:0][REG_W-1:0]   stg_dest,
    input  logic [NUM_SLOT-1:0]              stg_ready,
    output logic [NUM_OPS-1:0][SEL_W-1:0]    op_sel,
    output logic                             op_stall
);

    logic [NUM_OPS-1:0] op_hz;

    for (genvar o = 0; o < NUM_OPS; o++) begin : g_op
        logic [NUM_SLOT-1:0] hit;

        pb_match #(.REG_W(REG_W)) u_match (
            .src_reg   (op_reg[o]),
            .src_used  (op_used[o]),
            .stg_valid (stg_valid),
            .stg_dest  (stg_dest),
            .hit       (hit)
        );

        pb_pick u_pick (
            .hit       (hit),
            .stg_ready (stg_ready),
            .path_en   (op_path_en[o]),
            .sel       (op_sel[o]),
            .hazard    (op_hz[o])
        );
    end

    assign op_stall = |op_hz;

endmodule

// File: rtl/pb_bypass_ctrl_chk.sv
module pb_bypass_ctrl_chk
    import pb_pkg::*;
#(
    parameter int REG_W   = 5,
    parameter int NUM_OPS = 2
) (
    input logic [NUM_OPS-1:0][REG_W-1:0]    op_reg,
    input logic [NUM_OPS-1:0]               op_used,
    input logic [NUM_OPS-1:0][NUM_PATH-1:0] op_path_en,
    input logic [NUM_SLOT-1:0]              stg_valid,
    input logic [NUM_SLOT-1:0][REG_W-1:0]   stg_dest,
    input logic [NUM_SLOT-1:0]              stg_ready,
    input logic [NUM_OPS-1:0][SEL_W-1:0]    op_sel,
    input logic                             op_stall
);

    always_comb begin
        for (int o = 0; o < NUM_OPS; o++) begin
            assert_sel_shape_R2: assert ($onehot(op_sel[o]) || (op_sel[o] == '0 && op_stall))
                else $error("operand select malformed");
            assert_idle_operand_R3: assert (!(!op_used[o] || op_reg[o] == '0) || op_sel[o] == SEL_W'(1))
                else $error("unused operand not on register file");
            assert_no_stall_full_R9: assert (op_stall || op_sel[o] != '0)
                else $error("operand blocked without stall");
            for (int k = 0; k < NUM_PATH; k++) begin
                assert_fwd_enabled_R5: assert (!op_sel[o][k+1] || op_path_en[o][k])
                    else $error("forward over disabled path");
                assert_fwd_source_R4: assert (!op_sel[o][k+1] ||
                        (stg_valid[path_slot(k)] && stg_ready[path_slot(k)] &&
                         stg_dest[path_slot(k)] == op_reg[o]))
                    else $error("forward from non-matching stage");
            end
        end
    end

endmodule

bind pb_bypass_ctrl pb_bypass_ctrl_chk #(.REG_W(REG_W), .NUM_OPS(NUM_OPS)) u_chk (.*);

// File: tb/pb_bypass_ctrl_tb.sv
module pb_bypass_ctrl_tb;

    localparam int RW = 3;
    localparam int NO = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [NO-1:0][RW-1:0] op_reg;
    logic [NO-1:0]         op_used;
    logic [NO-1:0][6:0]    op_path_en;
    logic [8:0]            stg_valid;
    logic [8:0][RW-1:0]    stg_dest;
    logic [8:0]            stg_ready;
    logic [NO-1:0][7:0]    op_sel;
    logic                  op_stall;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    pb_bypass_ctrl #(.REG_W(RW), .NUM_OPS(NO)) u_dut (
        .op_reg(op_reg), .op_used(op_used), .op_path_en(op_path_en),
        .stg_valid(stg_valid), .stg_dest(stg_dest), .stg_ready(stg_ready),
        .op_sel(op_sel), .op_stall(op_stall)
    );

    // Slot order X1 M1 D1 X2 M2 D2 XWB MWB DWB -> mask bit, -1 = no wire
    function automatic int path_of(int s);
        int tbl [9] = '{0, -1, -1, 1, 3, 5, 2, 4, 6};
        return tbl[s];
    endfunction

    // Returns {hazard, sel[7:0]}
    function automatic logic [8:0] model(logic [RW-1:0] r, logic u, logic [6:0] m,
                                         logic [8:0] v, logic [8:0][RW-1:0] d,
                                         logic [8:0] rd);
        if (!u || r == 0) return 9'h001;
        for (int s = 0; s < 9; s++) begin
            if (v[s] && d[s] == r) begin
                int p = path_of(s);
                if (p >= 0 && m[p] && rd[s]) return 9'(1 << (p + 1));
                return 9'h100;
            end
        end
        return 9'h001;
    endfunction

    task automatic check(string tag);
        logic [8:0] e0, e1;
        logic es;
        @(negedge clk);
        e0 = model(op_reg[0], op_used[0], op_path_en[0], stg_valid, stg_dest, stg_ready);
        e1 = model(op_reg[1], op_used[1], op_path_en[1], stg_valid, stg_dest, stg_ready);
        es = e0[8] | e1[8];
        checks++;
        if (op_sel[0] !== e0[7:0] || op_sel[1] !== e1[7:0] || op_stall !== es) begin
            errors++;
            $display("FAIL %s: sel0=%b sel1=%b stall=%b expected sel0=%b sel1=%b stall=%b",
                     tag, op_sel[0], op_sel[1], op_stall, e0[7:0], e1[7:0], es);
        end
        @(posedge clk);
        #1;
    endtask

    task automatic clear_stages();
        stg_valid = '0;
        for (int s = 0; s < 9; s++) stg_dest[s] = RW'(5);
        stg_ready = '1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 190000);
        errors++;
        $display("FAIL watchdog: run did not complete, actual running expected done");
        finish_run();
    end

    initial begin
        logic [31:0] lfsr;
        op_reg = '0; op_used = '0; op_path_en = '0;
        clear_stages();
        @(posedge clk); #1;

        // R8: empty pipeline, both operands live
        op_reg[0] = 3'd3; op_reg[1] = 3'd6; op_used = 2'b11; op_path_en = '1;
        check("R8 idle");

        // R5 R6 R7: lone producer in every slot, ready or not, every mask
        op_used = 2'b01;
        for (int s = 0; s < 9; s++)
            for (int rd = 0; rd < 2; rd++)
                for (int m = 0; m < 128; m++) begin
                    clear_stages();
                    stg_valid[4'(s)] = 1'b1; stg_dest[4'(s)] = 3'd3;
                    stg_ready[4'(s)] = 1'(rd);
                    op_path_en[0] = 7'(m);
                    check(rd == 0 ? "R7 not ready" : "R5/R6 single producer");
                end

        // R4: two writers of the same register, younger decides
        for (int y = 0; y < 9; y++)
            for (int o = y + 1; o < 9; o++)
                for (int m = 0; m < 128; m++) begin
                    clear_stages();
                    stg_valid[4'(y)] = 1'b1; stg_dest[4'(y)] = 3'd3;
                    stg_valid[4'(o)] = 1'b1; stg_dest[4'(o)] = 3'd3;
                    op_path_en[0] = 7'(m);
                    check("R4 youngest writer");
                end

        // R3: register 0 and unused operands ignore matching stages
        stg_valid = '1; stg_ready = '0;
        for (int s = 0; s < 9; s++) stg_dest[s] = '0;
        op_reg[0] = '0; op_used = 2'b11; op_path_en = '0;
        op_reg[1] = 3'd0;
        check("R3 register zero");
        for (int s = 0; s < 9; s++) stg_dest[s] = 3'd2;
        op_reg[0] = 3'd2; op_reg[1] = 3'd2; op_used = 2'b00;
        check("R3 unused operand");

        // R1: configuration 28 forwards from M2, not from X2
        clear_stages(); op_used = 2'b01; op_reg[0] = 3'd4; op_path_en[0] = 7'd28;
        stg_valid[4] = 1'b1; stg_dest[4] = 3'd4;
        check("R1 mask 28 M2");
        clear_stages(); stg_valid[3] = 1'b1; stg_dest[3] = 3'd4;
        check("R1 mask 28 X2");

        // R9: independent masks, first only X2/D2, second without MWB/XWB
        clear_stages(); op_used = 2'b11;
        op_reg[0] = 3'd2; op_reg[1] = 3'd2;
        op_path_en[0] = 7'b0100010; op_path_en[1] = 7'b1101011;
        stg_valid[7] = 1'b1; stg_dest[7] = 3'd2;
        check("R9 MWB for both");
        clear_stages(); stg_valid[5] = 1'b1; stg_dest[5] = 3'd2;
        check("R9 D2 for both");
        clear_stages(); stg_valid[3] = 1'b1; stg_dest[3] = 3'd2;
        check("R9 X2 for both");

        // R2 R9: random mixes of both operands
        lfsr = 32'h1ACE_B00C;
        for (int i = 0; i < 3000; i++) begin
            for (int b = 0; b < 8; b++) lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            stg_valid = lfsr[8:0];
            stg_ready = lfsr[17:9];
            op_reg[0] = lfsr[20:18]; op_reg[1] = lfsr[23:21];
            op_used = lfsr[25:24] | 2'b01;
            op_path_en[0] = lfsr[31:25];
            op_path_en[1] = lfsr[6:0] ^ lfsr[30:24];
            for (int s = 0; s < 9; s++) stg_dest[s] = 3'(lfsr >> (s * 3));
            check("R2/R9 random");
        end

        finish_run();
    end

endmodule